// File: doc/BRIEF.md
# Card Detect Event Tracker

This block monitors the status pins of up to two PC card sockets: two card-detect pins, two battery-voltage pins, ready/busy, write-protect and a card access timeout. Every pin is resynchronised with two flops. Any edge of the resynchronised level is latched as a change bit in a per-socket status register. Software acknowledges these bits by writing ones. A per-socket enable lets latched changes drive a single registered status-change interrupt, which is meant for the higher-priority of the host's two interrupt inputs.

The block also keeps an occupied flag for each socket. It raises an insertion strobe when both detect pins of an empty socket read high. It raises a removal strobe when both detect pins of an occupied socket read low. A card that is only half seated, with one detect pin high, produces no strobe. Each strobe is a one-cycle pulse on the bit of `ins_evt` or `rem_evt` whose index is the socket number.

Register access goes through a small port. `reg_sel` picks the socket and `reg_addr` picks the register: 0 is status and 1 is control. A write happens in the cycle `reg_we` is high. The read data is combinational.

Top module: `card_event_tracker`

## Requirements
- R1: After reset, every status and control register reads zero, `irq_status` is low, and no strobe is active.
- R2: When both detect pins of a socket read high and its occupied flag is clear, exactly one insertion pulse appears on that socket's bit of `ins_evt`, and the occupied flag (status bit 6) sets.
- R3: When both detect pins of a socket read low and its occupied flag is set, exactly one removal pulse appears on that socket's bit of `rem_evt`, and the occupied flag clears.
- R4: While the two detect pins of a socket disagree, no strobe fires and the occupied flag keeps its value.
- R5: A rising or falling edge on a synchronised pin sets its change bit in the status register, and the bit stays set until it is cleared. The bit positions are: detect (either pin) bit 0, battery 1 bit 1, battery 2 bit 2, ready bit 3, write-protect bit 4, timeout bit 5. Bit 7 reads zero.
- R6: A write to status (address 0) clears exactly the change bits written as one, and bits written as zero are unaffected. Writing 0x3F acknowledges all six bits at once.
- R7: If a clearing write and a new edge reach the same change bit in one cycle, the bit stays set.
- R8: A battery-voltage edge is not latched if it occurs in the same cycle as a detect edge, or while the detect change bit is already set.
- R9: `irq_status` is high one cycle after any socket has a nonzero change field with its enable (control bit 0) set. It is low when no enabled socket has a pending change.
- R10: Sockets are independent: events, change bits, enables and clears of one socket do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_a_in | input | NSOCK | First card-detect pin per socket, high = detected |
| det_b_in | input | NSOCK | Second card-detect pin per socket, high = detected |
| batt1_in | input | NSOCK | Battery voltage 1 pin per socket |
| batt2_in | input | NSOCK | Battery voltage 2 pin per socket |
| ready_in | input | NSOCK | Ready/busy pin per socket |
| wprot_in | input | NSOCK | Write-protect pin per socket |
| tmo_in | input | NSOCK | Card access timeout pin per socket |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = control |
| reg_sel | input | SW | Socket select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_status | output | 1 | Status-change interrupt |
| ins_evt | output | NSOCK | One-cycle insertion strobe, indexed by socket |
| rem_evt | output | NSOCK | One-cycle removal strobe, indexed by socket |

## Verification
The bench goes after the half-seated card. A design that tests either detect pin instead of both would report an insertion or removal while the second pin still disagrees.

It lands a clearing write in the very cycle a fresh write-protect edge arrives. A design that gives the clear priority would lose that event.

It changes a battery pin together with a detect pin, and again while the detect change is still pending. A design without suppression would report those battery bits.

It checks that a zero in a clearing write leaves its bit alone, that the interrupt stays low for a socket whose enable is off, and that activity on socket 1 leaves socket 0's registers and strobes unchanged.

// File: rtl/card_event_tracker.sv
module card_event_tracker #(
  parameter int NSOCK = 2,
  localparam int SW = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSOCK-1:0] det_a_in,
  input  logic [NSOCK-1:0] det_b_in,
  input  logic [NSOCK-1:0] batt1_in,
  input  logic [NSOCK-1:0] batt2_in,
  input  logic [NSOCK-1:0] ready_in,
  input  logic [NSOCK-1:0] wprot_in,
  input  logic [NSOCK-1:0] tmo_in,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [SW-1:0]    reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_status,
  output logic [NSOCK-1:0] ins_evt,
  output logic [NSOCK-1:0] rem_evt
);
  localparam int NPIN = 7;
  localparam int NCHG = 6;

  logic [NSOCK-1:0][NPIN-1:0] raw, s1, s2, prev;
  logic [NSOCK-1:0][NCHG-1:0] chg, set_bits, clr_mask;
  logic [NSOCK-1:0]           occ, en, both_on, both_off, ctl_hit, pend;

  for (genvar g = 0; g < NSOCK; g++) begin : g_pack
    assign raw[g] = {tmo_in[g], wprot_in[g], ready_in[g], batt2_in[g],
                     batt1_in[g], det_b_in[g], det_a_in[g]};
  end

  always_comb begin
    for (int s = 0; s < NSOCK; s++) begin
      logic [NPIN-1:0] edg;
      logic det_edge, bv_ok, sel_hit;
      edg      = s2[s] ^ prev[s];
      det_edge = edg[0] | edg[1];
      bv_ok    = !(det_edge || chg[s][0]);
      sel_hit  = reg_we && (reg_sel == SW'(s));
      set_bits[s] = {edg[6], edg[5], edg[4], edg[3] & bv_ok, edg[2] & bv_ok, det_edge};
      clr_mask[s] = (sel_hit && !reg_addr) ? reg_wdata[NCHG-1:0] : '0;
      ctl_hit[s]  = sel_hit && reg_addr;
      both_on[s]  = s2[s][0] & s2[s][1];
      both_off[s] = !(s2[s][0] | s2[s][1]);
      pend[s]     = en[s] && (chg[s] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev <= '0;
      chg <= '0;
      occ <= '0;
      en <= '0;
      ins_evt <= '0;
      rem_evt <= '0;
      irq_status <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      prev <= s2;
      irq_status <= |pend;
      for (int s = 0; s < NSOCK; s++) begin
        chg[s] <= (chg[s] & ~clr_mask[s]) | set_bits[s];
        if (ctl_hit[s]) en[s] <= reg_wdata[0];
        ins_evt[s] <= both_on[s] & !occ[s];
        rem_evt[s] <= both_off[s] & occ[s];
        if (both_on[s]) occ[s] <= 1'b1;
        else if (both_off[s]) occ[s] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NSOCK; s++)
      if (reg_sel == SW'(s))
        reg_rdata = reg_addr ? {7'b0, en[s]} : {1'b0, occ[s], chg[s]};
  end
endmodule

// File: rtl/card_event_tracker_chk.sv
module card_event_tracker_chk #(
  parameter int NSOCK = 2,
  localparam int SW = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSOCK-1:0]      ins_evt,
  input logic [NSOCK-1:0]      rem_evt,
  input logic [NSOCK-1:0]      occ,
  input logic [NSOCK-1:0]      en,
  input logic [NSOCK-1:0][5:0] chg,
  input logic                  irq_status,
  input logic                  reg_we,
  input logic                  reg_addr,
  input logic [SW-1:0]         reg_sel
);
  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    a_r2_insert_sets_occ: assert property (@(posedge clk) disable iff (!rst_n)
      ins_evt[s] |-> (occ[s] && !$past(occ[s])));
    a_r3_remove_clears_occ: assert property (@(posedge clk) disable iff (!rst_n)
      rem_evt[s] |-> (!occ[s] && $past(occ[s])));
    a_r4_occ_moves_with_event: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[s] != $past(occ[s])) |-> (ins_evt[s] || rem_evt[s]));
    a_r6_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((chg[s] != '0) && !(reg_we && !reg_addr && reg_sel == SW'(s)))
        |=> ((chg[s] & $past(chg[s])) == $past(chg[s])));
  end

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq_status);
endmodule

bind card_event_tracker card_event_tracker_chk #(.NSOCK(NSOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_evt(ins_evt), .rem_evt(rem_evt),
  .occ(occ), .en(en), .chg(chg), .irq_status(irq_status),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_sel(reg_sel)
);

// File: tb/card_event_tracker_test.sv
`timescale 1ns/1ps
module card_event_tracker_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] det_a = 0, det_b = 0, bat1 = 0, bat2 = 0, rdy = 0, wpr = 0, tmo = 0;
  logic reg_we = 0, reg_addr = 0;
  logic [0:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_status;
  logic [1:0] ins_evt, rem_evt;
  int n_chk = 0, n_bad = 0;
  int ins_cnt[2] = '{0, 0};
  int rem_cnt[2] = '{0, 0};

  always #4 clk = ~clk;

  card_event_tracker #(.NSOCK(2)) uut (
    .clk(clk), .rst_n(rst_n), .det_a_in(det_a), .det_b_in(det_b),
    .batt1_in(bat1), .batt2_in(bat2), .ready_in(rdy), .wprot_in(wpr), .tmo_in(tmo),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_status(irq_status), .ins_evt(ins_evt), .rem_evt(rem_evt));

  always @(negedge clk) if (rst_n) begin
    ins_cnt[0] += int'(ins_evt[0]); ins_cnt[1] += int'(ins_evt[1]);
    rem_cnt[0] += int'(rem_evt[0]); rem_cnt[1] += int'(rem_evt[1]);
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(int s, bit a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s[0]; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int s, bit a, output logic [7:0] v);
    reg_sel = s[0]; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic toggle0(int i);
    case (i)
      1: bat1[0] = ~bat1[0];
      2: bat2[0] = ~bat2[0];
      3: rdy[0]  = ~rdy[0];
      4: wpr[0]  = ~wpr[0];
      default: tmo[0] = ~tmo[0];
    endcase
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 2; s++) begin
      rd(s, 0, v); chk("R1 status", v, 0);
      rd(s, 1, v); chk("R1 control", v, 0);
    end
    chk("R1 irq", irq_status, 0);
    chk("R1 strobes", {ins_evt, rem_evt}, 0);
  endtask

  task automatic t_insert();
    logic [7:0] v;
    @(negedge clk); det_a[0] = 1; det_b[0] = 1;
    settle(); settle();
    chk("R2 one insertion", ins_cnt[0], 1);
    chk("R2 no removal", rem_cnt[0], 0);
    rd(0, 0, v); chk("R2 status occupied", v, 8'h41);
    wr(0, 0, 8'h3F);
    rd(0, 0, v); chk("R6 clear all", v, 8'h40);
  endtask

  task automatic t_remove();
    logic [7:0] v;
    @(negedge clk); det_a[0] = 0;
    settle();
    chk("R4 half removal no event", rem_cnt[0], 0);
    rd(0, 0, v); chk("R4 occ kept", v, 8'h41);
    @(negedge clk); det_b[0] = 0;
    settle();
    chk("R3 one removal", rem_cnt[0], 1);
    rd(0, 0, v); chk("R3 occ cleared", v, 8'h01);
    wr(0, 0, 8'h3F);
    @(negedge clk); det_b[0] = 1;
    settle();
    chk("R4 half insert no event", ins_cnt[0], 1);
    rd(0, 0, v); chk("R4 empty kept", v, 8'h01);
    @(negedge clk); det_b[0] = 0;
    settle();
    wr(0, 0, 8'h3F);
  endtask

  task automatic t_sources();
    logic [7:0] v;
    for (int i = 1; i < 6; i++) begin
      @(negedge clk); toggle0(i);
      settle();
      rd(0, 0, v); chk($sformatf("R5 rise src %0d", i), v, 1 << i);
      wr(0, 0, 8'h3F);
      @(negedge clk); toggle0(i);
      settle();
      rd(0, 0, v); chk($sformatf("R5 fall src %0d", i), v, 1 << i);
      wr(0, 0, 8'h3F);
    end
  endtask

  task automatic t_partial_clear();
    logic [7:0] v;
    @(negedge clk); rdy[0] = 1; wpr[0] = 1;
    settle();
    rd(0, 0, v); chk("R5 two bits", v, 8'h18);
    wr(0, 0, 8'h08);
    rd(0, 0, v); chk("R6 clear one", v, 8'h10);
    wr(0, 0, 8'h00);
    rd(0, 0, v); chk("R6 zero write keeps", v, 8'h10);
    wr(0, 0, 8'h3F);
    rd(0, 0, v); chk("R6 clear rest", v, 8'h00);
  endtask

  task automatic t_bv_suppress();
    logic [7:0] v;
    @(negedge clk); det_a[0] = 1; bat1[0] = ~bat1[0];
    settle();
    rd(0, 0, v); chk("R8 bv with detect", v, 8'h01);
    @(negedge clk); bat2[0] = ~bat2[0];
    settle();
    rd(0, 0, v); chk("R8 bv while detect pending", v, 8'h01);
    wr(0, 0, 8'h3F);
    @(negedge clk); bat1[0] = ~bat1[0];
    settle();
    rd(0, 0, v); chk("R8 bv alone", v, 8'h02);
    @(negedge clk); det_a[0] = 0;
    settle();
    wr(0, 0, 8'h3F);
  endtask

  task automatic t_edge_wins();
    logic [7:0] v;
    @(negedge clk); tmo[0] = ~tmo[0];
    settle();
    @(negedge clk); wpr[0] = ~wpr[0];
    @(negedge clk);
    wr(0, 0, 8'h3F);
    rd(0, 0, v); chk("R7 edge beats clear", v, 8'h10);
    wr(0, 0, 8'h3F);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(1, 1, 8'h01);
    rd(1, 1, v); chk("R10 ctrl sock1", v, 8'h01);
    rd(0, 1, v); chk("R10 ctrl sock0 untouched", v, 8'h00);
    @(negedge clk); rdy[0] = ~rdy[0];
    settle();
    chk("R9 disabled socket no irq", irq_status, 0);
    wr(0, 1, 8'h01);
    settle();
    chk("R9 irq raised", irq_status, 1);
    wr(0, 0, 8'h3F);
    settle();
    chk("R9 irq dropped", irq_status, 0);
    wr(0, 1, 8'h00);
    wr(1, 1, 8'h00);
  endtask

  task automatic t_socket1();
    logic [7:0] v;
    @(negedge clk); det_a[1] = 1; det_b[1] = 1;
    settle();
    chk("R10 sock1 insertion", ins_cnt[1], 1);
    chk("R10 sock0 no extra", ins_cnt[0], 1);
    rd(1, 0, v); chk("R10 sock1 status", v, 8'h41);
    rd(0, 0, v); chk("R10 sock0 status", v, 8'h00);
    wr(0, 0, 8'h3F);
    rd(1, 0, v); chk("R10 cross clear", v, 8'h41);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    settle();
    t_reset();
    t_insert();
    t_remove();
    t_sources();
    t_partial_clear();
    t_bv_suppress();
    t_edge_wins();
    t_irq();
    t_socket1();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule